// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O peripheral that groups its pins into banks of 32. Software controls each bank through a small set of word registers: a read-only view of the synchronized pin levels and a direction register. It also has write-one-to-set and write-one-to-clear strobes for the output value, and separate enables for rising and falling edges. An edge status register is cleared by writing ones, and an edge mask decides which captured edges may interrupt the processor.

Pins enter through a two-flop synchronizer. An edge is found by comparing the synchronized sample with the one taken a cycle earlier. Pins 0 and 1 each have a dedicated interrupt line. Every pin's masked status also feeds one combined interrupt line. A parameter mask marks pins whose direction bit has inverted polarity. Banks are laid out three to a 256-byte group, one word apart, so that a single register kind for three banks sits in consecutive words.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: Bank n answers at byte address ((n/3)<<8) + ((n%3)<<2) plus a kind offset. The kind offsets are 0x00 level, 0x0C direction, 0x18 set, 0x24 clear, 0x30 rising enable, 0x3C falling enable, 0x48 edge status and 0x9C edge mask. Read data is registered and appears on `reg_rdata` one cycle after the address is presented.
- R2: A read of an offset outside that map, or of a bank index at or beyond NUM_BANKS, returns zero. A write to such an address changes no register and no output.
- R3: A write to the set offset raises the output bits given as ones. A write to the clear offset lowers them. Zero bits leave the output unchanged. Reading either offset returns the current output register, which drives `pin_out` directly.
- R4: The level offset returns `pin_in` after two synchronizer flops, whatever the direction of the pins.
- R5: `pin_oe` of a pin equals its direction bit, except for pins selected in DIR_INV (default pins 40 to 43), where a direction bit of 0 enables the output.
- R6: A status bit becomes 1 one cycle after the synchronized input shows a 0-to-1 step while its rising enable is set, or a 1-to-0 step while its falling enable is set. Steps without the matching enable set nothing.
- R7: Writing a one to a status bit clears it. Writing a zero leaves it unchanged.
- R8: When a new edge and a clearing write hit the same status bit in the same cycle, the bit stays 1.
- R9: `irq_any` is the OR over all pins of status AND mask. `irq_pin0` and `irq_pin1` are status AND mask of pins 0 and 1.
- R10: After reset, the direction, output, enable, status and mask registers are zero. As a result `pin_out` is zero, `pin_oe` equals DIR_INV, every interrupt is low, and `reg_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | NUM_BANKS*32 | Raw pin inputs |
| pin_out | output | NUM_BANKS*32 | Output value per pin |
| pin_oe | output | NUM_BANKS*32 | Output enable per pin |
| irq_pin0 | output | 1 | Masked edge status of pin 0 |
| irq_pin1 | output | 1 | Masked edge status of pin 1 |
| irq_any | output | 1 | OR of all masked edge status bits |

## Verification
A corrupted output or direction register shows on `pin_out` or `pin_oe` in the same cycle the register takes its wrong value, without any read. A status bit that is set without cause, or fails to clear, shows as a wrong `irq_any` or dedicated interrupt as soon as its mask bit is 1. Otherwise it shows only on the next read of the status offset. A decode slip between banks shows one cycle after the read, as data that belongs to a neighbouring bank or kind.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

    localparam int BANK_PINS = 32;

    typedef enum logic [3:0] {
        RK_LEVEL = 4'd0,
        RK_DIR   = 4'd1,
        RK_SET   = 4'd2,
        RK_CLR   = 4'd3,
        RK_RISE  = 4'd4,
        RK_FALL  = 4'd5,
        RK_STAT  = 4'd6,
        RK_MASK  = 4'd7,
        RK_NONE  = 4'd15
    } reg_kind_e;

    typedef struct packed {
        logic [BANK_PINS-1:0] outv;
        logic [BANK_PINS-1:0] dir;
        logic [BANK_PINS-1:0] rise_en;
        logic [BANK_PINS-1:0] fall_en;
        logic [BANK_PINS-1:0] stat;
        logic [BANK_PINS-1:0] emask;
    } bank_state_t;

endpackage

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] now_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] now;
        logic [W-1:0] prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_i;
        st_d.now  = st_q.meta;
        st_d.prev = st_q.now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign now_o  = st_q.now;
    assign prev_o = st_q.prev;

endmodule

// File: rtl/gpio_regmap.sv
module gpio_regmap
    import gpio_banked_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 12,
    parameter int BANK_W    = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              hit_o
);

    localparam int KINDS_LINEAR = 7;
    localparam int BANKS_PER_GRP = 3;
    localparam int MASK_WORD     = 39;

    int word_i;
    int grp_i;
    int sub_i;
    int slot_i;

    always_comb begin
        word_i = int'(addr_i[7:2]);
        grp_i  = int'(addr_i[ADDR_W-1:8]);
        kind_o = RK_NONE;
        sub_i  = 0;
        if (word_i < KINDS_LINEAR * BANKS_PER_GRP) begin
            kind_o = reg_kind_e'(4'(word_i / BANKS_PER_GRP));
            sub_i  = word_i % BANKS_PER_GRP;
        end else if (word_i >= MASK_WORD && word_i < MASK_WORD + BANKS_PER_GRP) begin
            kind_o = RK_MASK;
            sub_i  = word_i - MASK_WORD;
        end
        slot_i = grp_i * BANKS_PER_GRP + sub_i;
        hit_o  = (kind_o != RK_NONE) && (slot_i < NUM_BANKS);
        bank_o = hit_o ? slot_i[BANK_W-1:0] : '0;
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_banked_pkg::*;
#(
    parameter logic [BANK_PINS-1:0] INV_MASK = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  reg_kind_e            wr_kind,
    input  logic [BANK_PINS-1:0] wdata,
    input  logic [BANK_PINS-1:0] pin_now,
    input  logic [BANK_PINS-1:0] pin_prev,
    output logic [BANK_PINS-1:0] out_o,
    output logic [BANK_PINS-1:0] oe_o,
    output logic [BANK_PINS-1:0] dir_o,
    output logic [BANK_PINS-1:0] rise_o,
    output logic [BANK_PINS-1:0] fall_o,
    output logic [BANK_PINS-1:0] stat_o,
    output logic [BANK_PINS-1:0] emask_o
);

    bank_state_t st_d, st_q;
    logic [BANK_PINS-1:0] edge_ev;

    always_comb begin
        edge_ev = (pin_now & ~pin_prev & st_q.rise_en)
                | (~pin_now & pin_prev & st_q.fall_en);
        st_d = st_q;
        if (wr_en) begin
            case (wr_kind)
                RK_DIR:  st_d.dir     = wdata;
                RK_SET:  st_d.outv    = st_q.outv | wdata;
                RK_CLR:  st_d.outv    = st_q.outv & ~wdata;
                RK_RISE: st_d.rise_en = wdata;
                RK_FALL: st_d.fall_en = wdata;
                RK_STAT: st_d.stat    = st_q.stat & ~wdata;
                RK_MASK: st_d.emask   = wdata;
                default: ;
            endcase
        end
        st_d.stat = st_d.stat | edge_ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o   = st_q.outv;
    assign oe_o    = st_q.dir ^ INV_MASK;
    assign dir_o   = st_q.dir;
    assign rise_o  = st_q.rise_en;
    assign fall_o  = st_q.fall_en;
    assign stat_o  = st_q.stat;
    assign emask_o = st_q.emask;

    assert_edge_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev != '0) |=> ((stat_o & $past(edge_ev)) == $past(edge_ev)));

    assert_no_spurious_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(edge_ev)) == '0));

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == RK_STAT) |=>
            ((stat_o & $past(wdata) & ~$past(edge_ev)) == '0));

    assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == RK_STAT && (wdata & edge_ev) != '0) |=>
            ((stat_o & $past(wdata & edge_ev)) == $past(wdata & edge_ev)));

    assert_set_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == RK_SET) |=> ((out_o & $past(wdata)) == $past(wdata)));

    assert_clr_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == RK_CLR) |=> ((out_o & $past(wdata)) == '0));

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_banked_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 12,
    parameter logic [NUM_BANKS*32-1:0] DIR_INV =
        {{(NUM_BANKS*32-4){1'b0}}, 4'hF} << 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_we,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic [NUM_BANKS*32-1:0] pin_in,
    output logic [NUM_BANKS*32-1:0] pin_out,
    output logic [NUM_BANKS*32-1:0] pin_oe,
    output logic                    irq_pin0,
    output logic                    irq_pin1,
    output logic                    irq_any
);

    localparam int PINS   = NUM_BANKS * BANK_PINS;
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [PINS-1:0] pin_now, pin_prev, masked_all;
    reg_kind_e       dec_kind;
    logic [BANK_W-1:0] dec_bank;
    logic            dec_hit;

    logic [BANK_PINS-1:0] dir_a   [NUM_BANKS];
    logic [BANK_PINS-1:0] out_a   [NUM_BANKS];
    logic [BANK_PINS-1:0] rise_a  [NUM_BANKS];
    logic [BANK_PINS-1:0] fall_a  [NUM_BANKS];
    logic [BANK_PINS-1:0] stat_a  [NUM_BANKS];
    logic [BANK_PINS-1:0] emask_a [NUM_BANKS];

    gpio_insync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .now_o  (pin_now),
        .prev_o (pin_prev)
    );

    gpio_regmap #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_map (
        .addr_i (reg_addr),
        .kind_o (dec_kind),
        .bank_o (dec_bank),
        .hit_o  (dec_hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = reg_we && dec_hit && (dec_bank == BANK_W'(b));

        gpio_bank #(.INV_MASK(DIR_INV[b*BANK_PINS +: BANK_PINS])) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .wr_kind  (dec_kind),
            .wdata    (reg_wdata),
            .pin_now  (pin_now[b*BANK_PINS +: BANK_PINS]),
            .pin_prev (pin_prev[b*BANK_PINS +: BANK_PINS]),
            .out_o    (out_a[b]),
            .oe_o     (pin_oe[b*BANK_PINS +: BANK_PINS]),
            .dir_o    (dir_a[b]),
            .rise_o   (rise_a[b]),
            .fall_o   (fall_a[b]),
            .stat_o   (stat_a[b]),
            .emask_o  (emask_a[b])
        );

        assign pin_out[b*BANK_PINS +: BANK_PINS]    = out_a[b];
        assign masked_all[b*BANK_PINS +: BANK_PINS] = stat_a[b] & emask_a[b];
    end

    typedef struct packed {
        logic [31:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (dec_hit) begin
            case (dec_kind)
                RK_LEVEL: rd_d.rdata = pin_now[int'(dec_bank)*BANK_PINS +: BANK_PINS];
                RK_DIR:   rd_d.rdata = dir_a[dec_bank];
                RK_SET,
                RK_CLR:   rd_d.rdata = out_a[dec_bank];
                RK_RISE:  rd_d.rdata = rise_a[dec_bank];
                RK_FALL:  rd_d.rdata = fall_a[dec_bank];
                RK_STAT:  rd_d.rdata = stat_a[dec_bank];
                RK_MASK:  rd_d.rdata = emask_a[dec_bank];
                default:  rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata = rd_q.rdata;
    assign irq_pin0  = masked_all[0];
    assign irq_pin1  = masked_all[1];
    assign irq_any   = |masked_all;

    assert_unmapped_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |=> (reg_rdata == '0));

    assert_stray_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !dec_hit) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(!rst_n) |-> (pin_out == '0 && pin_oe == DIR_INV && !irq_any));

endmodule

// File: tb/gpio_banked_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_banked_ctrl_bench;

    localparam int NB = 3;
    localparam int NP = NB * 32;
    localparam logic [NP-1:0] INV = {{(NP-4){1'b0}}, 4'hF} << 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq_pin0, irq_pin1, irq_any;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    gpio_banked_ctrl u_gpio_banked_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1), .irq_any(irq_any)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h00C, 32'h1234_5678, 32'h0,         4'd1},  // R1 dir bank0
        '{1'b0, 12'h00C, 32'h0,         32'h1234_5678, 4'd1},
        '{1'b1, 12'h010, 32'hFFFF_FFFF, 32'h0,         4'd1},  // R1 dir bank1
        '{1'b0, 12'h010, 32'h0,         32'hFFFF_FFFF, 4'd1},
        '{1'b0, 12'h00C, 32'h0,         32'h1234_5678, 4'd1},
        '{1'b1, 12'h020, 32'h0000_00FF, 32'h0,         4'd3},  // R3 set bank2
        '{1'b0, 12'h020, 32'h0,         32'h0000_00FF, 4'd3},
        '{1'b1, 12'h02C, 32'h0000_000F, 32'h0,         4'd3},  // R3 clear bank2
        '{1'b0, 12'h02C, 32'h0,         32'h0000_00F0, 4'd3},
        '{1'b1, 12'h030, 32'hAAAA_0000, 32'h0,         4'd1},  // R1 rise bank0
        '{1'b0, 12'h030, 32'h0,         32'hAAAA_0000, 4'd1},
        '{1'b1, 12'h044, 32'h0F0F_0F0F, 32'h0,         4'd1},  // R1 fall bank2
        '{1'b0, 12'h044, 32'h0,         32'h0F0F_0F0F, 4'd1},
        '{1'b1, 12'h0A4, 32'hCAFE_F00D, 32'h0,         4'd1},  // R1 mask bank2
        '{1'b0, 12'h0A4, 32'h0,         32'hCAFE_F00D, 4'd1},
        '{1'b0, 12'h09C, 32'h0,         32'h0,         4'd10}, // R10 mask bank0
        '{1'b1, 12'h100, 32'hFFFF_FFFF, 32'h0,         4'd2},  // R2 bank3 absent
        '{1'b0, 12'h100, 32'h0,         32'h0,         4'd2},
        '{1'b0, 12'h054, 32'h0,         32'h0,         4'd2},  // R2 gap offset
        '{1'b1, 12'h060, 32'h5555_5555, 32'h0,         4'd2},
        '{1'b0, 12'h060, 32'h0,         32'h0,         4'd2},
        '{1'b0, 12'h010, 32'h0,         32'hFFFF_FFFF, 4'd2}   // R2 no side effect
    };

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        do_reset();

        // R10 reset state
        chk("R10 pin_out", pin_out, '0);
        chk("R10 pin_oe", pin_oe, INV);
        chk("R10 irq", {irq_any, irq_pin1, irq_pin0}, '0);
        chk("R10 rdata", reg_rdata, '0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            else begin
                rd(VEC[i].addr, r);
                chk($sformatf("R%0d table[%0d]", VEC[i].req, i), r, VEC[i].exp);
            end
        end

        do_reset();
        // R5 direction polarity
        wr(12'h010, 32'hFFFF_FFFF);
        chk("R5 oe bank1", pin_oe[63:32], 32'hFFFF_F0FF);
        chk("R5 oe bank0", pin_oe[31:0], 32'h0);
        // R3 pads
        wr(12'h020, 32'h0000_00FF);
        wr(12'h02C, 32'h0000_000F);
        chk("R3 pin_out bank2", pin_out[95:64], 32'h0000_00F0);
        chk("R3 pin_out others", pin_out[63:0], '0);
        // R4 level regardless of direction
        @(negedge clk);
        pin_in[95:64] = 32'h5A5A_1234;
        pin_in[63:32] = 32'h0F0F_0F0F;
        idle(4);
        rd(12'h008, r); chk("R4 level bank2", r, 32'h5A5A_1234);
        rd(12'h004, r); chk("R4 level output bank1", r, 32'h0F0F_0F0F);
        @(negedge clk);
        pin_in = '0;
        idle(4);
        wr(12'h048, 32'hFFFF_FFFF);
        wr(12'h04C, 32'hFFFF_FFFF);
        wr(12'h050, 32'hFFFF_FFFF);
        rd(12'h048, r); chk("R7 cleared", r, 32'h0);

        // R6 edges: rise on pins 0,5; fall on pin 1
        wr(12'h030, 32'h0000_0021);
        wr(12'h03C, 32'h0000_0002);
        @(negedge clk);
        pin_in[5:0] = 6'b100011;
        idle(4);
        rd(12'h048, r); chk("R6 rising", r, 32'h0000_0021);
        chk("R9 masked off", {irq_any, irq_pin1, irq_pin0}, '0);
        @(negedge clk);
        pin_in[5:0] = '0;
        idle(4);
        rd(12'h048, r); chk("R6 falling", r, 32'h0000_0023);
        // R9 mask gating
        wr(12'h09C, 32'h0000_0002);
        chk("R9 pin1 only", {irq_any, irq_pin1, irq_pin0}, 3'b110);
        wr(12'h09C, 32'h0000_0001);
        chk("R9 pin0 only", {irq_any, irq_pin1, irq_pin0}, 3'b101);
        wr(12'h09C, 32'h0000_0020);
        chk("R9 other pin", {irq_any, irq_pin1, irq_pin0}, 3'b100);
        // R7 write-one-to-clear
        wr(12'h048, 32'h0000_0020);
        rd(12'h048, r); chk("R7 w1c", r, 32'h0000_0003);
        chk("R7 irq drop", irq_any, 1'b0);
        wr(12'h048, 32'h0);
        rd(12'h048, r); chk("R7 zero write", r, 32'h0000_0003);
        wr(12'h048, 32'h0000_0003);

        // R8 collision: bit 5 set first, then clear and new edge together
        @(negedge clk); pin_in[5] = 1'b1;
        idle(4);
        @(negedge clk); pin_in[5] = 1'b0;
        idle(4);
        rd(12'h048, r); chk("R8 pre", r, 32'h0000_0020);
        @(negedge clk); pin_in[5] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_addr = 12'h048; reg_wdata = 32'h0000_0020; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk); reg_we = 1'b0;
        rd(12'h048, r); chk("R8 edge wins", r, 32'h0000_0020);
        wr(12'h048, 32'h0000_0020);
        rd(12'h048, r); chk("R7 after collision", r, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule